// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This block performs the one-operand arithmetic, logic, shift and byte-swap operations of a 16-bit minicomputer-style datapath. It computes the new condition codes N (negative), Z (zero), V (overflow) and C (carry). An operand, a carry input, a 4-bit operation code and a byte-mode select go in. The result leaves combinationally in the same cycle. The four flags are held in a register that loads only when a one-cycle `valid` strobe is high.

Each operation applies its own rule to each flag. When an operation does not define a flag, that flag keeps the value already in the flag register. In byte mode the operation works on bits 7:0 and treats bit 7 as the sign, while bits 15:8 of the operand pass through to the result untouched. Byte swap and sign extend always work on the full word. The carry used by add-carry, subtract-carry and the two rotates comes from the `c_in` port.

Top module: `mono_alu`

## Requirements
- R1: `nzvc` is 4'b0000 while `rst_n` is low. It loads the new flags on a rising clock edge where `valid` is 1 and keeps its value on an edge where `valid` is 0. The flag order is `nzvc[3]`=N, `nzvc[2]`=Z, `nzvc[1]`=V, `nzvc[0]`=C.
- R2: Op 0 (clear) gives result 0 and flags N=0, Z=1, V=0, C=0.
- R3: Op 1 (complement) gives the bitwise inverse with C=1 and V=0. Unless a rule says otherwise, N is the sign bit of the result and Z is 1 when the result is zero.
- R4: Op 2 (increment) sets V only when the result is 16'h8000 (8'h80 in byte mode). Op 3 (decrement) sets V only when the result is 16'h7FFF (8'h7F). Both leave C at its registered value.
- R5: Op 4 (negate) gives the two's complement, sets C when the result is nonzero and sets V when the result is the most negative value.
- R6: Op 5 adds `c_in`. Its V is set when the result is the most negative value and `c_in`=1, and its C is set when the result is zero and `c_in`=1. Op 6 subtracts `c_in`. Its C is set when `c_in`=1 and the operand is zero, and its V is set when the result is the most negative value.
- R7: Op 7 (test) outputs the operand unchanged, takes N and Z from it, and clears V and C.
- R8: Op 8 rotates right and op 9 rotates left, both through `c_in`. The bit shifted out becomes C.
- R9: Op 10 shifts right arithmetically and keeps the sign bit. Op 11 shifts left with a zero in. C takes the bit shifted out, and for ops 8 to 11 V equals N xor C after the operation.
- R10: Op 12 exchanges the two bytes and clears V and C. N is bit 7 of the result and Z is 1 when result bits 7:0 are zero.
- R11: Op 13 outputs 16'hFFFF when the registered N is 1 and 16'h0000 otherwise. It sets Z to the inverse of the registered N, clears V, and keeps N and C.
- R12: With `byte_mode`=1, ops 0 to 11 work on bits 7:0 with bit 7 as the sign, and result bits 15:8 equal operand bits 15:8. Ops 12 and 13 ignore `byte_mode`.
- R13: Ops 14 and 15 are reserved. Their result equals the operand and all four flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | One-cycle strobe that loads the flag register |
| op | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects the 8-bit operation |
| operand | input | 16 | Operand |
| c_in | input | 1 | Carry input to add/subtract-carry and the rotates |
| result | output | 16 | Combinational result |
| nzvc | output | 4 | Registered flags {N,Z,V,C} |

## Verification
The bench tries every operation code in both widths and with both carry inputs. It uses operands at the boundaries: zero, one, all ones, the largest positive value, the most negative value and its neighbour, one-byte-only values and a few mixed patterns. These show whether the overflow and carry rules trigger on exactly the right value and not on a neighbour. Each case runs from two starting flag states, all clear with Z set and N/C set. This separates flags that an operation writes from flags it must keep, and it drives both outcomes of sign extend. Idle cycles with a different operation code on the inputs show that the register holds without the strobe.

// File: rtl/mono_alu_pkg.sv
package mono_alu_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned NFLAG  = 4;
  localparam int unsigned OP_W   = 4;

  // flag vector positions
  localparam int unsigned FN = 3;
  localparam int unsigned FZ = 2;
  localparam int unsigned FV = 1;
  localparam int unsigned FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_CLR  = 4'd0,
    OP_COM  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_NEG  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_TST  = 4'd7,
    OP_ROR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ASR  = 4'd10,
    OP_ASL  = 4'd11,
    OP_SWAB = 4'd12,
    OP_SXT  = 4'd13
  } op_e;

endpackage

// File: rtl/mono_alu_lane.sv
module mono_alu_lane
  import mono_alu_pkg::*;
#(
  parameter int unsigned LW = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [LW-1:0]    a,
  input  logic             c_in,
  input  logic [NFLAG-1:0] prev,
  output logic [LW-1:0]    res,
  output logic [NFLAG-1:0] flg
);

  localparam int unsigned MSB = LW - 1;
  localparam int unsigned HW  = LW / 2;
  localparam logic [LW-1:0] MOST_NEG = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MOST_POS = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] ONE      = {{(LW-1){1'b0}}, 1'b1};

  logic [LW-1:0] cin_ext;
  logic          n_d, z_d, v_d, c_d;
  logic          nz_from_res;
  logic          is_shift;

  assign cin_ext = {{(LW-1){1'b0}}, c_in};

  always_comb begin
    res         = a;
    n_d         = prev[FN];
    z_d         = prev[FZ];
    v_d         = prev[FV];
    c_d         = prev[FC];
    nz_from_res = 1'b1;
    is_shift    = 1'b0;
    case (op)
      OP_CLR: begin
        res = '0;
        v_d = 1'b0;
        c_d = 1'b0;
      end
      OP_COM: begin
        res = ~a;
        v_d = 1'b0;
        c_d = 1'b1;
      end
      OP_INC: begin
        res = a + ONE;
        v_d = (res == MOST_NEG);
      end
      OP_DEC: begin
        res = a - ONE;
        v_d = (res == MOST_POS);
      end
      OP_NEG: begin
        res = ~a + ONE;
        v_d = (res == MOST_NEG);
        c_d = (res != '0);
      end
      OP_ADC: begin
        res = a + cin_ext;
        v_d = c_in & (res == MOST_NEG);
        c_d = c_in & (res == '0);
      end
      OP_SBC: begin
        res = a - cin_ext;
        v_d = (res == MOST_NEG);
        c_d = c_in & (a == '0);
      end
      OP_TST: begin
        res = a;
        v_d = 1'b0;
        c_d = 1'b0;
      end
      OP_ROR: begin
        res      = {c_in, a[MSB:1]};
        c_d      = a[0];
        is_shift = 1'b1;
      end
      OP_ROL: begin
        res      = {a[MSB-1:0], c_in};
        c_d      = a[MSB];
        is_shift = 1'b1;
      end
      OP_ASR: begin
        res      = {a[MSB], a[MSB:1]};
        c_d      = a[0];
        is_shift = 1'b1;
      end
      OP_ASL: begin
        res      = {a[MSB-1:0], 1'b0};
        c_d      = a[MSB];
        is_shift = 1'b1;
      end
      OP_SWAB: begin
        res         = {a[HW-1:0], a[LW-1:HW]};
        n_d         = res[HW-1];
        z_d         = (res[HW-1:0] == '0);
        v_d         = 1'b0;
        c_d         = 1'b0;
        nz_from_res = 1'b0;
      end
      OP_SXT: begin
        res         = {LW{prev[FN]}};
        z_d         = ~prev[FN];
        v_d         = 1'b0;
        nz_from_res = 1'b0;
      end
      default: begin
        res         = a;
        nz_from_res = 1'b0;
      end
    endcase
    if (nz_from_res) begin
      n_d = res[MSB];
      z_d = (res == '0);
    end
    if (is_shift) begin
      v_d = n_d ^ c_d;
    end
  end

  always_comb begin
    flg     = '0;
    flg[FN] = n_d;
    flg[FZ] = z_d;
    flg[FV] = v_d;
    flg[FC] = c_d;
  end

endmodule

// File: rtl/mono_alu_flagreg.sv
module mono_alu_flagreg
  import mono_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NFLAG-1:0] d,
  output logic [NFLAG-1:0] q
);

  logic [NFLAG-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/mono_alu.sv
module mono_alu
  import mono_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [OP_W-1:0]   op,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] operand,
  input  logic              c_in,
  output logic [DATA_W-1:0] result,
  output logic [NFLAG-1:0]  nzvc
);

  localparam int unsigned BW = DATA_W / 2;

  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  flags_new;
  logic [DATA_W-1:0] word_res;
  logic [NFLAG-1:0]  word_flg;
  logic [BW-1:0]     byte_res;
  logic [NFLAG-1:0]  byte_flg;
  logic              word_only_op;
  logic              use_byte;

  mono_alu_lane #(.LW(DATA_W)) u_word_lane (
    .op   (op),
    .a    (operand),
    .c_in (c_in),
    .prev (flags_q),
    .res  (word_res),
    .flg  (word_flg)
  );

  mono_alu_lane #(.LW(BW)) u_byte_lane (
    .op   (op),
    .a    (operand[BW-1:0]),
    .c_in (c_in),
    .prev (flags_q),
    .res  (byte_res),
    .flg  (byte_flg)
  );

  assign word_only_op = (op == OP_SWAB) || (op == OP_SXT);
  assign use_byte     = byte_mode && !word_only_op;

  always_comb begin
    if (use_byte) begin
      result    = {operand[DATA_W-1:BW], byte_res};
      flags_new = byte_flg;
    end else begin
      result    = word_res;
      flags_new = word_flg;
    end
  end

  mono_alu_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (valid),
    .d     (flags_new),
    .q     (flags_q)
  );

  assign nzvc = flags_q;

endmodule

// File: rtl/mono_alu_chk.sv
module mono_alu_chk
  import mono_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic [OP_W-1:0]   op,
  input logic              byte_mode,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] result,
  input logic [NFLAG-1:0]  nzvc
);

  logic is_shift_op;
  logic nz_plain_op;
  assign is_shift_op = (op >= OP_ROR) && (op <= OP_ASL);
  assign nz_plain_op = (op <= OP_ASL);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(nzvc)); // R1

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_CLR |=> nzvc == 4'b0100); // R2

  AST_COM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == OP_COM |=> nzvc[FC] && !nzvc[FV]); // R3

  AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == OP_INC || op == OP_DEC) |=> nzvc[FC] == $past(nzvc[FC])); // R4

  AST_TST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_TST |-> result == operand); // R7

  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_shift_op |=> nzvc[FV] == (nzvc[FN] ^ nzvc[FC])); // R9

  AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !byte_mode && nz_plain_op |=> nzvc[FZ] == ($past(result) == '0)); // R3

  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode && op < OP_SWAB |-> result[DATA_W-1:DATA_W/2] == operand[DATA_W-1:DATA_W/2]); // R12

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op > OP_SXT |=> $stable(nzvc)); // R13

endmodule

bind mono_alu mono_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid     (valid),
  .op        (op),
  .byte_mode (byte_mode),
  .operand   (operand),
  .result    (result),
  .nzvc      (nzvc)
);

// File: tb/mono_alu_test.sv
`timescale 1ns/1ps
module mono_alu_test;

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic [3:0]  op;
  logic        byte_mode;
  logic [15:0] operand;
  logic        c_in;
  logic [15:0] result;
  logic [3:0]  nzvc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] cur_flags;

  mono_alu uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .byte_mode(byte_mode),
    .operand(operand), .c_in(c_in), .result(result), .nzvc(nzvc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_of(int o, bit bm);
    if (bm && o <= 11) return "R12";
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8, 9: return "R8";
      10, 11: return "R9";
      12: return "R10";
      13: return "R11";
      default: return "R13";
    endcase
  endfunction

  // returns {result[15:0], n, z, v, c}
  function automatic logic [19:0] model(int o, bit bm, logic [15:0] a, bit ci, logic [3:0] pf);
    int w, mask, sgn, x, r, full;
    bit n, z, v, c, nz_auto;
    w    = (bm && o != 12 && o != 13) ? 8 : 16;
    mask = (1 << w) - 1;
    sgn  = 1 << (w - 1);
    x    = int'(a) & mask;
    n = pf[3]; z = pf[2]; v = pf[1]; c = pf[0];
    nz_auto = 1;
    r = x;
    case (o)
      0:  begin r = 0; v = 0; c = 0; end
      1:  begin r = (~x) & mask; v = 0; c = 1; end
      2:  begin r = (x + 1) & mask; v = (r == sgn); end
      3:  begin r = (x - 1) & mask; v = (r == sgn - 1); end
      4:  begin r = (0 - x) & mask; v = (r == sgn); c = (r != 0); end
      5:  begin r = (x + int'(ci)) & mask; v = (r == sgn) && ci; c = (r == 0) && ci; end
      6:  begin r = (x - int'(ci)) & mask; v = (r == sgn); c = ci && (x == 0); end
      7:  begin r = x; v = 0; c = 0; end
      8:  begin r = (x >> 1) | (ci ? sgn : 0); c = x[0]; end
      9:  begin r = ((x << 1) & mask) | int'(ci); c = (x & sgn) != 0; end
      10: begin r = (x >> 1) | (x & sgn); c = x[0]; end
      11: begin r = (x << 1) & mask; c = (x & sgn) != 0; end
      12: begin
        r = ((x & 255) << 8) | (x >> 8);
        n = (r & 128) != 0; z = (r & 255) == 0; v = 0; c = 0; nz_auto = 0;
      end
      13: begin r = pf[3] ? 65535 : 0; z = !pf[3]; v = 0; nz_auto = 0; end
      default: nz_auto = 0;
    endcase
    if (nz_auto) begin
      n = (r & sgn) != 0;
      z = (r == 0);
    end
    if (o >= 8 && o <= 11) v = n ^ c;
    full = (w == 8) ? ((int'(a) & 16'hFF00) | r) : r;
    return {full[15:0], n, z, v, c};
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(int o, bit bm, logic [15:0] a, bit ci);
    logic [19:0] e;
    string tag;
    @(negedge clk);
    op = 4'(o); byte_mode = bm; operand = a; c_in = ci; valid = 1'b1;
    e   = model(o, bm, a, ci, cur_flags);
    tag = req_of(o, bm);
    #1;
    check(result === e[19:4], tag, result, e[19:4], "result");
    @(negedge clk);
    valid = 1'b0;
    check(nzvc === e[3:0], tag, {12'h0, nzvc}, {12'h0, e[3:0]}, "flags");
    cur_flags = e[3:0];
  endtask

  task automatic idle_hold();
    @(negedge clk);
    valid = 1'b0; op = 4'd1; operand = 16'h0000; c_in = ~c_in;
    @(negedge clk);
    check(nzvc === cur_flags, "R1", {12'h0, nzvc}, {12'h0, cur_flags}, "hold without strobe");
  endtask

  initial begin
    logic [15:0] pats [0:17];
    pats[0] = 16'h0000; pats[1] = 16'h0001; pats[2] = 16'h007F; pats[3] = 16'h0080;
    pats[4] = 16'h00FF; pats[5] = 16'h0100; pats[6] = 16'h7FFF; pats[7] = 16'h8000;
    pats[8] = 16'h8001; pats[9] = 16'hFFFF; pats[10] = 16'hFF00; pats[11] = 16'h1234;
    pats[12] = 16'hA5C3; pats[13] = 16'h4000; pats[14] = 16'hFF80; pats[15] = 16'h017F;
    pats[16] = 16'h8081; pats[17] = 16'h5A00;
    rst_n = 1'b0; valid = 1'b0; op = '0; byte_mode = 1'b0; operand = '0; c_in = 1'b0;
    cur_flags = 4'b0000;
    repeat (3) @(negedge clk);
    check(nzvc === 4'b0000, "R1", {12'h0, nzvc}, 16'h0, "reset value");
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++) begin
      for (int bm = 0; bm < 2; bm++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int pk = 0; pk < 2; pk++) begin
            for (int p = 0; p < 18; p++) begin
              if (pk == 0) step(0, 1'b0, 16'h1111, 1'b0);
              else         step(1, 1'b0, 16'h0000, 1'b0);
              step(o, bm[0], pats[p], ci[0]);
            end
          end
        end
      end
      idle_hold();
    end
    // asynchronous reset clears a nonzero state
    step(1, 1'b0, 16'h0000, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check(nzvc === 4'b0000, "R1", {12'h0, nzvc}, 16'h0, "async reset");
    @(negedge clk);
    rst_n = 1'b1;
    cur_flags = 4'b0000;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule